// File: doc/BRIEF.md
# Latency-Configurable Memory with Split Readwrite Port

This block wraps a register-built storage array, which reads combinationally and writes in one cycle, in valid-tagged delay stages. The stages give the memory a read latency and a write latency that are set at elaboration. Software-invisible and single-clocked, it is meant to sit wherever a design needs a memory whose timing must match a pipeline's schedule rather than the natural timing of the storage.

Three access ports share the array. The first is a read-only port and the second a write-only port with a per-lane byte-style mask. The third is a combined port that either reads or writes in a given cycle, chosen by a mode input. Inside the block that combined port becomes one independent read path and one independent write path.

A read-collision parameter chooses how reads relate to writes at the same address. In "old" mode the address reaches the array at once and the delay is applied to the returned data. In the other modes the address is delayed and the data comes straight from the array. A constant output reports whether the configuration is simple enough to map onto a plain one-cycle synchronous memory.

Top module: `mem_lat_top`

## Requirements
- R1: A read accepted in a cycle (rd_en=1 on the read port; rw_en=1 with rw_wmode=0 on the combined port) raises that port's valid output (rd_valid or rw_rvalid) exactly RD_LAT clock edges later. Cycles with no accepted read leave the valid low at the matching edge.
- R2: In old mode (RUW=RUW_OLD) the returned word is the array content during the issue cycle. A write that commits at the edge ending that cycle is not seen.
- R3: In the other modes the read address is delayed by RD_LAT edges and the data output shows the array at the delayed address combinationally. With RD_LAT=1 and WR_LAT=1, a read and a write to the same address in the same cycle return the new word.
- R4: A write presented in cycle t is committed at the WR_LAT-th rising edge from the one that samples it. A read that reaches the array after that edge returns the new word.
- R5: Write data is split into LANES lanes, with lane i at bits [i*LANE_W +: LANE_W] controlled by mask bit i. Only lanes whose mask bit is 1 change, and an all-zero mask changes nothing.
- R6: On the combined port, rw_wmode=1 writes and produces no read response, and rw_wmode=0 reads and writes nothing, whatever rw_wdata holds.
- R7: When both write paths commit to the same address at the same edge, the combined port's word wins on every lane that both enable.
- R8: In old mode with RD_LAT at least 1, a port's data output keeps its previous value at every edge where its valid output is low.
- R9: A synchronous active-high rst clears every valid stage, including reads in flight. The storage and the data stages are not reset.
- R10: cfg_simple is 1 exactly when RD_LAT<=1, WR_LAT==1, and either HAS_RW=0 or (RD_LAT==1 and RUW is not RUW_NEW).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of valid stages |
| rd_en | input | 1 | Read request on the read-only port |
| rd_addr | input | AW | Read-only port address |
| rd_data | output | LANES*LANE_W | Read-only port returned word |
| rd_valid | output | 1 | Read-only port response valid |
| wr_en | input | 1 | Write request on the write-only port |
| wr_addr | input | AW | Write-only port address |
| wr_mask | input | LANES | Write-only port lane enables |
| wr_data | input | LANES*LANE_W | Write-only port word |
| rw_en | input | 1 | Combined port request |
| rw_wmode | input | 1 | Combined port: 1 write, 0 read |
| rw_addr | input | AW | Combined port address |
| rw_wmask | input | LANES | Combined port lane enables |
| rw_wdata | input | LANES*LANE_W | Combined port write word |
| rw_rdata | output | LANES*LANE_W | Combined port returned word |
| rw_rvalid | output | 1 | Combined port response valid |
| cfg_simple | output | 1 | Configuration maps onto a one-cycle synchronous memory |

## Verification
On every cycle the assertions check that each port's response valid follows its accepted reads by exactly RD_LAT edges, that the combined port's write cycles never produce a response, and that in old mode the data outputs stay still when no response emerges. Only the bench scenarios can show what the returned words contain. This covers old versus new data on a same-edge collision, lane masking, a zero mask, write latency, the combined port's write-mode split, write priority between ports, reset of in-flight reads and the simple-configuration flag.

// File: rtl/mem_lat_pkg.sv
package mem_lat_pkg;

    // Behaviour of a read that meets a write to the same word
    typedef enum logic [1:0] {
        RUW_UNDEF = 2'd0,
        RUW_OLD   = 2'd1,
        RUW_NEW   = 2'd2
    } ruw_mode_e;

    // True when the timing fits a plain one-cycle synchronous memory
    function automatic logic simple_cfg(input int rd_lat, input int wr_lat,
                                        input bit has_rw, input ruw_mode_e mode);
        return (rd_lat <= 1) && (wr_lat == 1) &&
               (!has_rw || ((rd_lat == 1) && (mode != RUW_NEW)));
    endfunction

endpackage

// File: rtl/mem_lat_pipe.sv
// Valid-tagged delay line: valid bits always advance, payload advances only
// behind a high valid. STAGES=0 is a plain wire.
module mem_lat_pipe #(
    parameter int STAGES = 1,
    parameter int W      = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);

    generate
        if (STAGES == 0) begin : g_wire
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign out_vld        = in_vld;
            assign out_dat        = in_dat;
        end else begin : g_regs
            typedef struct packed {
                logic [STAGES-1:0]        vld;
                logic [STAGES-1:0][W-1:0] dat;
            } pipe_t;

            pipe_t st_d, st_q;

            always_comb begin
                st_d        = st_q;
                st_d.vld[0] = in_vld;
                if (in_vld) begin
                    st_d.dat[0] = in_dat;
                end
                for (int s = 1; s < STAGES; s++) begin
                    st_d.vld[s] = st_q.vld[s-1];
                    if (st_q.vld[s-1]) begin
                        st_d.dat[s] = st_q.dat[s-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q.vld <= '0;
                end else begin
                    st_q.vld <= st_d.vld;
                end
                st_q.dat <= st_d.dat;
            end

            assign out_vld = st_q.vld[STAGES-1];
            assign out_dat = st_q.dat[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/mem_lat_array.sv
// Register array: combinational reads of the current contents, masked
// writes committed at the clock edge. Higher write ports win collisions.
module mem_lat_array #(
    parameter int DEPTH  = 16,
    parameter int AW     = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int NRD    = 2,
    parameter int NWR    = 2
) (
    input  logic                                clk,
    input  logic [NRD-1:0][AW-1:0]              rd_addr,
    output logic [NRD-1:0][LANES*LANE_W-1:0]    rd_data,
    input  logic [NWR-1:0]                      wr_en,
    input  logic [NWR-1:0][AW-1:0]              wr_addr,
    input  logic [NWR-1:0][LANES-1:0]           wr_mask,
    input  logic [NWR-1:0][LANES*LANE_W-1:0]    wr_data
);

    typedef logic [DEPTH-1:0][LANES-1:0][LANE_W-1:0] store_t;

    store_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int p = 0; p < NWR; p++) begin
            if (wr_en[p]) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wr_mask[p][l]) begin
                        mem_d[wr_addr[p]][l] = wr_data[p][l*LANE_W +: LANE_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            assign rd_data[r] = mem_q[rd_addr[r]];
        end
    endgenerate

endmodule

// File: rtl/mem_lat_top.sv
module mem_lat_top #(
    parameter int                    AW     = 4,
    parameter int                    LANES  = 4,
    parameter int                    LANE_W = 8,
    parameter int                    RD_LAT = 2,
    parameter int                    WR_LAT = 2,
    parameter mem_lat_pkg::ruw_mode_e RUW   = mem_lat_pkg::RUW_OLD,
    parameter bit                    HAS_RW = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_en,
    input  logic [AW-1:0]             rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data,
    output logic                      rd_valid,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [LANES-1:0]          wr_mask,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic                      rw_en,
    input  logic                      rw_wmode,
    input  logic [AW-1:0]             rw_addr,
    input  logic [LANES-1:0]          rw_wmask,
    input  logic [LANES*LANE_W-1:0]   rw_wdata,
    output logic [LANES*LANE_W-1:0]   rw_rdata,
    output logic                      rw_rvalid,
    output logic                      cfg_simple
);

    localparam int  DW      = LANES * LANE_W;
    localparam int  DEPTH   = 1 << AW;
    localparam bit  OLD     = (RUW == mem_lat_pkg::RUW_OLD);
    localparam int  RCMD    = OLD ? 0 : RD_LAT;
    localparam int  RRSP    = OLD ? RD_LAT : 0;
    localparam int  WCMD    = WR_LAT - 1;
    localparam int  WPW     = AW + LANES + DW;
    localparam int  NPORT   = 2;

    generate
        if (WR_LAT < 1 || RD_LAT < 0) begin : g_bad_cfg
            $error("mem_lat_top: WR_LAT must be >= 1 and RD_LAT >= 0");
        end
    endgenerate

    // Index 0: dedicated port, index 1: readwrite port
    logic [NPORT-1:0]           rq_vld,   ac_vld,   rs_vld;
    logic [NPORT-1:0][AW-1:0]   rq_addr,  arr_raddr;
    logic [NPORT-1:0][DW-1:0]   arr_rdata, rs_dat;
    logic [NPORT-1:0]           wq_vld,   wc_vld;
    logic [NPORT-1:0][WPW-1:0]  wq_pay,   wc_pay;
    logic [NPORT-1:0][AW-1:0]   arr_waddr;
    logic [NPORT-1:0][LANES-1:0] arr_wmask;
    logic [NPORT-1:0][DW-1:0]   arr_wdata;

    // Readwrite port split by write mode
    assign rq_vld[0]  = rd_en;
    assign rq_addr[0] = rd_addr;
    assign rq_vld[1]  = HAS_RW && rw_en && !rw_wmode;
    assign rq_addr[1] = rw_addr;

    assign wq_vld[0]  = wr_en;
    assign wq_pay[0]  = {wr_addr, wr_mask, wr_data};
    assign wq_vld[1]  = HAS_RW && rw_en && rw_wmode;
    assign wq_pay[1]  = {rw_addr, rw_wmask, rw_wdata};

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_port
            mem_lat_pipe #(.STAGES(RCMD), .W(AW)) i_rcmd (
                .clk     (clk),
                .rst     (rst),
                .in_vld  (rq_vld[g]),
                .in_dat  (rq_addr[g]),
                .out_vld (ac_vld[g]),
                .out_dat (arr_raddr[g])
            );

            mem_lat_pipe #(.STAGES(RRSP), .W(DW)) i_rrsp (
                .clk     (clk),
                .rst     (rst),
                .in_vld  (ac_vld[g]),
                .in_dat  (arr_rdata[g]),
                .out_vld (rs_vld[g]),
                .out_dat (rs_dat[g])
            );

            mem_lat_pipe #(.STAGES(WCMD), .W(WPW)) i_wcmd (
                .clk     (clk),
                .rst     (rst),
                .in_vld  (wq_vld[g]),
                .in_dat  (wq_pay[g]),
                .out_vld (wc_vld[g]),
                .out_dat (wc_pay[g])
            );

            assign arr_waddr[g] = wc_pay[g][WPW-1 -: AW];
            assign arr_wmask[g] = wc_pay[g][DW +: LANES];
            assign arr_wdata[g] = wc_pay[g][DW-1:0];
        end
    endgenerate

    mem_lat_array #(
        .DEPTH  (DEPTH),
        .AW     (AW),
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .NRD    (NPORT),
        .NWR    (NPORT)
    ) i_array (
        .clk     (clk),
        .rd_addr (arr_raddr),
        .rd_data (arr_rdata),
        .wr_en   (wc_vld),
        .wr_addr (arr_waddr),
        .wr_mask (arr_wmask),
        .wr_data (arr_wdata)
    );

    assign rd_data    = rs_dat[0];
    assign rd_valid   = rs_vld[0];
    assign rw_rdata   = rs_dat[1];
    assign rw_rvalid  = rs_vld[1];
    assign cfg_simple = mem_lat_pkg::simple_cfg(RD_LAT, WR_LAT, HAS_RW, RUW);

endmodule

// File: rtl/mem_lat_chk.sv
module mem_lat_chk #(
    parameter int                     RD_LAT = 2,
    parameter bit                     HAS_RW = 1'b1,
    parameter mem_lat_pkg::ruw_mode_e RUW    = mem_lat_pkg::RUW_OLD,
    parameter int                     DW     = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic          rw_en,
    input logic          rw_wmode,
    input logic          rd_valid,
    input logic          rw_rvalid,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] rw_rdata
);

    localparam int H = (RD_LAT > 0) ? RD_LAT : 1;

    logic         rw_issue;
    logic [H-1:0] rd_hist_q, rw_hist_q;
    logic         exp_rd_vld, exp_rw_vld;

    assign rw_issue = HAS_RW && rw_en && !rw_wmode;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hist_q <= '0;
            rw_hist_q <= '0;
        end else begin
            rd_hist_q <= (rd_hist_q << 1) | H'(rd_en);
            rw_hist_q <= (rw_hist_q << 1) | H'(rw_issue);
        end
    end

    assign exp_rd_vld = (RD_LAT == 0) ? rd_en    : rd_hist_q[H-1];
    assign exp_rw_vld = (RD_LAT == 0) ? rw_issue : rw_hist_q[H-1];

    // R1
    rd_valid_track_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid == exp_rd_vld);

    // R6
    rw_valid_track_chk: assert property (@(posedge clk) disable iff (rst)
        rw_rvalid == exp_rw_vld);

    // R9
    valid_known_chk: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({rd_valid, rw_rvalid}));

    generate
        if (RUW == mem_lat_pkg::RUW_OLD && RD_LAT > 0) begin : g_hold
            // R8
            rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !rd_valid |-> $stable(rd_data));

            // R8
            rw_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !rw_rvalid |-> $stable(rw_rdata));
        end
    endgenerate

endmodule

bind mem_lat_top mem_lat_chk #(
    .RD_LAT (RD_LAT),
    .HAS_RW (HAS_RW),
    .RUW    (RUW),
    .DW     (LANES*LANE_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rw_en     (rw_en),
    .rw_wmode  (rw_wmode),
    .rd_valid  (rd_valid),
    .rw_rvalid (rw_rvalid),
    .rd_data   (rd_data),
    .rw_rdata  (rw_rdata)
);

// File: tb/test_mem_lat_top.sv
module test_mem_lat_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_en, wr_en, rw_en, rw_wmode;
    logic [3:0]  rd_addr, wr_addr, rw_addr, wr_mask, rw_wmask;
    logic [31:0] wr_data, rw_wdata;

    logic [31:0] a_rd_data, a_rw_rdata, b_rd_data, b_rw_rdata, c_rd_data, c_rw_rdata;
    logic        a_rd_valid, a_rw_rvalid, b_rd_valid, b_rw_rvalid, c_rd_valid, c_rw_rvalid;
    logic        a_simple, b_simple, c_simple;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    // Old mode, read latency 2, write latency 2
    mem_lat_top i_mem_lat_top (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(a_rd_data),
        .rd_valid(a_rd_valid), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .wr_data(wr_data), .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_addr(rw_addr),
        .rw_wmask(rw_wmask), .rw_wdata(rw_wdata), .rw_rdata(a_rw_rdata),
        .rw_rvalid(a_rw_rvalid), .cfg_simple(a_simple));

    // New-data mode, read latency 1, write latency 1
    mem_lat_top #(.RD_LAT(1), .WR_LAT(1), .RUW(mem_lat_pkg::RUW_NEW)) i_mem_lat_top_new (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(b_rd_data),
        .rd_valid(b_rd_valid), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .wr_data(wr_data), .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_addr(rw_addr),
        .rw_wmask(rw_wmask), .rw_wdata(rw_wdata), .rw_rdata(b_rw_rdata),
        .rw_rvalid(b_rw_rvalid), .cfg_simple(b_simple));

    // Old mode, both latencies 1: the simple case
    mem_lat_top #(.RD_LAT(1), .WR_LAT(1), .RUW(mem_lat_pkg::RUW_OLD)) i_mem_lat_top_simple (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(c_rd_data),
        .rd_valid(c_rd_valid), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .wr_data(wr_data), .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_addr(rw_addr),
        .rw_wmask(rw_wmask), .rw_wdata(rw_wdata), .rw_rdata(c_rw_rdata),
        .rw_rvalid(c_rw_rvalid), .cfg_simple(c_simple));

    typedef struct packed {
        logic        wr_en;
        logic [3:0]  wr_addr;
        logic [3:0]  wr_mask;
        logic [31:0] wr_data;
        logic        rw_en;
        logic        rw_wm;
        logic [3:0]  rw_addr;
        logic [3:0]  rw_mask;
        logic [31:0] rw_wdata;
        logic        rd_en;
        logic [3:0]  rd_addr;
        logic        ck_rd;
        logic [31:0] exp_rd;
        logic        ck_rw;
        logic [31:0] exp_rw;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 22;

    // Each row drives one cycle; the expected words are the ones seen after
    // that cycle's rising edge on the old-mode instance (RD_LAT 2, WR_LAT 2).
    localparam vec_t VEC [NVEC] = '{
        '{1'b1,4'd3,4'hF,32'h11223344, 1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd3, 1'b0,32'h0,        1'b0,32'h0,        4'd0},
        '{1'b1,4'd5,4'hF,32'hA5A5A5A5, 1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd3, 1'b0,32'h0,        1'b0,32'h0,        4'd0},
        '{1'b1,4'd3,4'h5,32'hFFEEDDCC, 1'b0,1'b0,4'd0,4'h0,32'h0, 1'b1,4'd3, 1'b0,32'h0,        1'b0,32'h0,        4'd0},
        // R1: word read in row 2
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b1,4'd3, 1'b1,32'h11223344, 1'b0,32'h0,        4'd1},
        // R2: row 3 read sees old word while the masked write commits
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b1,4'd3, 1'b1,32'h11223344, 1'b0,32'h0,        4'd2},
        // R4: masked write visible after WR_LAT edges (lanes 0 and 2 only)
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b1,4'd5, 1'b1,32'h11EE33CC, 1'b0,32'h0,        4'd4},
        // R1: word at address 5
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd3, 1'b1,32'hA5A5A5A5, 1'b0,32'h0,        4'd1},
        // R8: no response, output holds
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd3, 1'b1,32'hA5A5A5A5, 1'b0,32'h0,        4'd8},
        '{1'b0,4'd0,4'h0,32'h0,        1'b1,1'b1,4'd7,4'hF,32'h01020304, 1'b0,4'd7, 1'b0,32'h0, 1'b0,32'h0,        4'd0},
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd3, 1'b0,32'h0,        1'b0,32'h0,        4'd0},
        '{1'b0,4'd0,4'h0,32'h0,        1'b1,1'b0,4'd7,4'hF,32'hDEADBEEF, 1'b0,4'd3, 1'b0,32'h0, 1'b0,32'h0,        4'd0},
        // R6: combined-port read returns its own earlier write
        '{1'b0,4'd0,4'h0,32'h0,        1'b1,1'b1,4'd5,4'hF,32'h55555555, 1'b0,4'd3, 1'b0,32'h0, 1'b1,32'h01020304, 4'd6},
        // R6: write-mode cycle gives no response, output holds
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd5, 1'b0,32'h0,        1'b1,32'h01020304, 4'd6},
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b1,4'd5, 1'b0,32'h0,        1'b0,32'h0,        4'd0},
        // R6: combined-port write reached the array
        '{1'b1,4'd5,4'h0,32'h00000000, 1'b0,1'b0,4'd0,4'h0,32'h0, 1'b1,4'd7, 1'b1,32'h55555555, 1'b0,32'h0,        4'd6},
        // R6: read-mode cycle did not write its data
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd7, 1'b1,32'h01020304, 1'b0,32'h0,        4'd6},
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b1,4'd5, 1'b0,32'h0,        1'b0,32'h0,        4'd0},
        // R5: zero-mask write changed nothing
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd5, 1'b1,32'h55555555, 1'b0,32'h0,        4'd5},
        '{1'b1,4'd2,4'hF,32'h11111111, 1'b1,1'b1,4'd2,4'hF,32'h22222222, 1'b0,4'd2, 1'b0,32'h0, 1'b0,32'h0,        4'd0},
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd2, 1'b0,32'h0,        1'b0,32'h0,        4'd0},
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b1,4'd2, 1'b0,32'h0,        1'b0,32'h0,        4'd0},
        // R7: combined-port write wins the same-edge collision
        '{1'b0,4'd0,4'h0,32'h0,        1'b0,1'b0,4'd0,4'h0,32'h0, 1'b0,4'd2, 1'b1,32'h22222222, 1'b0,32'h0,        4'd7}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        rd_en = 1'b0; wr_en = 1'b0; rw_en = 1'b0; rw_wmode = 1'b0;
        rd_addr = '0; wr_addr = '0; rw_addr = '0; wr_mask = '0; rw_wmask = '0;
        wr_data = '0; rw_wdata = '0;
    endtask

    initial begin
        logic prev_rd, prev_rw;
        idle();
        rst = 1'b1;
        rd_en = 1'b1; rw_en = 1'b1; rw_wmode = 1'b0;
        repeat (3) step();
        // R9: valids held clear during reset even with reads requested
        check("R9", "old rd_valid in reset", 32'(a_rd_valid), 32'd0);
        check("R9", "old rw_rvalid in reset", 32'(a_rw_rvalid), 32'd0);
        check("R9", "new rd_valid in reset", 32'(b_rd_valid), 32'd0);
        check("R9", "new rw_rvalid in reset", 32'(b_rw_rvalid), 32'd0);
        // R10: simple-configuration flag
        check("R10", "flag old RD2 WR2", 32'(a_simple), 32'd0);
        check("R10", "flag new RD1 WR1", 32'(b_simple), 32'd0);
        check("R10", "flag old RD1 WR1", 32'(c_simple), 32'd1);

        rst = 1'b0;
        idle();
        step();
        step();
        check("R1", "rd_valid idle after reset", 32'(a_rd_valid), 32'd0);

        prev_rd = 1'b0;
        prev_rw = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            wr_en    = VEC[i].wr_en;   wr_addr  = VEC[i].wr_addr;
            wr_mask  = VEC[i].wr_mask; wr_data  = VEC[i].wr_data;
            rw_en    = VEC[i].rw_en;   rw_wmode = VEC[i].rw_wm;
            rw_addr  = VEC[i].rw_addr; rw_wmask = VEC[i].rw_mask;
            rw_wdata = VEC[i].rw_wdata;
            rd_en    = VEC[i].rd_en;   rd_addr  = VEC[i].rd_addr;
            step();
            // RD_LAT=2: the valid seen now belongs to the previous row
            check("R1", $sformatf("row %0d rd_valid", i), 32'(a_rd_valid), 32'(prev_rd));
            check("R6", $sformatf("row %0d rw_rvalid", i), 32'(a_rw_rvalid), 32'(prev_rw));
            if (VEC[i].ck_rd)
                check($sformatf("R%0d", VEC[i].req), $sformatf("row %0d rd_data", i),
                      a_rd_data, VEC[i].exp_rd);
            if (VEC[i].ck_rw)
                check($sformatf("R%0d", VEC[i].req), $sformatf("row %0d rw_rdata", i),
                      a_rw_rdata, VEC[i].exp_rw);
            prev_rd = VEC[i].rd_en;
            prev_rw = VEC[i].rw_en && !VEC[i].rw_wm;
        end

        // R3: new-data instance returns a word written in the same cycle
        idle();
        wr_en = 1'b1; wr_addr = 4'd4; wr_mask = 4'hF; wr_data = 32'hCAFEF00D;
        rd_en = 1'b1; rd_addr = 4'd4;
        step();
        check("R1", "new rd_valid after 1 edge", 32'(b_rd_valid), 32'd1);
        check("R3", "new-data same-cycle collision", b_rd_data, 32'hCAFEF00D);

        idle();
        step();
        check("R1", "new rd_valid low without read", 32'(b_rd_valid), 32'd0);

        // R5: lanes 3 and 1 written, lanes 2 and 0 kept
        wr_en = 1'b1; wr_addr = 4'd4; wr_mask = 4'hA; wr_data = 32'h99887766;
        rd_en = 1'b1; rd_addr = 4'd4;
        step();
        check("R5", "partial lane write", b_rd_data, 32'h99FE770D);

        // R9: reset drops a read already in flight
        idle();
        rd_en = 1'b1; rd_addr = 4'd4;
        step();
        rd_en = 1'b0;
        rst = 1'b1;
        step();
        check("R9", "in-flight read cleared", 32'(a_rd_valid), 32'd0);
        rst = 1'b0;
        step();
        check("R9", "no response after reset", 32'(a_rd_valid), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule